// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the software-facing register file of a serial port. A processor reaches it over a simple synchronous bus with a word address, read and write strobes, write data and combinational read data. It holds three registers: a mode register with a master enable, a status/control register that mixes software enables with hardware-maintained flags, and a baud-divisor register. Every one of the three can also be written through clear, set and invert alias addresses, so software can change single bits without a read-modify-write race.

On the data side the block holds a single received character. It accepts bytes from the receive shifter through a one-cycle valid strobe that carries framing and parity error flags. It also passes written characters to the transmit shifter as a one-cycle strobe. Separate receive and transmit interrupt requests tell software when a character is waiting and when a character has been accepted for sending. Turning off the module, or turning off one direction, puts the hardware flags into a fixed state and drops the interrupts that belong to it.

Top module: `uart_csr_bank`

## Requirements
- R1: After reset every register, the receive slot and both interrupt requests read as zero, and the transmit strobe is low.
- R2: Word addresses 0, 4 and 12 hold mode, status and baud. The two low address bits select the write action: 0 stores the data, 1 stores old AND NOT data, 2 stores old OR data, and 3 stores old XOR data. All four actions have the same side effects.
- R3: Status bits 0 (receive data ready), 1 (framing error), 2 (parity error), 3 (receiver idle), 4 (transmit shifter empty) and 5 (transmit buffer full) keep their value on every software write to status. The other status bits take the written value. Bit 8 is the receive enable and bit 9 is the transmit enable.
- R4: When a mode write leaves bit 15 (module on) at 0, both interrupts drop. Status bits 0, 1, 2 and 5 clear, and bits 3 and 4 set. While the module is off, received bytes and transmit writes are ignored.
- R5: When a status write leaves the receive enable at 0, the receive interrupt drops and status bits 0 to 2 clear. Received bytes are ignored while receive is disabled.
- R6: When a status write leaves the transmit enable at 0, the transmit interrupt drops, status bit 5 clears and bit 4 sets.
- R7: A byte that arrives while the module is on and receive is enabled is stored in the slot on the next edge. On that edge status bit 0 sets, bits 1 and 2 take the byte's error flags, and the receive interrupt rises.
- R8: A read of address 9 returns the held byte and clears status bit 0 and the receive interrupt. If a new byte arrives in the same cycle, the new byte is stored and both stay set.
- R9: Address 8, every alias address, the unused addresses 10 and 11, and every address of 16 and above read as zero. Writes to address 9, 10, 11 or to addresses of 16 and above change nothing.
- R10: A write to address 8 while the module is on, transmit is enabled and no transmit interrupt is pending produces a one-cycle transmit strobe with the low data byte and raises the transmit interrupt. Any other write to address 8 produces no strobe.
- R11: A transmit acknowledge pulse clears the pending transmit interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (6) | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; triggers the receive-slot side effect |
| bus_wdata | input | RW (16) | Write data |
| bus_rdata | output | RW (16) | Combinational read data for bus_addr |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | CW (8) | Received byte |
| rx_ferr | input | 1 | Framing error of the received byte |
| rx_perr | input | 1 | Parity error of the received byte |
| tx_valid | output | 1 | Transmit byte strobe, one cycle |
| tx_data | output | CW (8) | Byte to transmit |
| tx_ack | input | 1 | Transmitter has taken the byte |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A corrupted mode or enable bit shows up one cycle later. Either a status read returns the wrong forced pattern, or an interrupt line stays high after software disabled it. A fault in the alias arithmetic or in the hardware-bit mask shows as a wrong value on the very next read-back of the same register. Errors in the receive-slot or transmit-pending state appear at the edge after the event that touches them. They show up as a missing or duplicated transmit strobe, a receive interrupt that fails to drop on a read, or a lost byte when a read and an arrival coincide.

// File: rtl/uart_csr_bank.sv
`timescale 1ns/1ps
module uart_csr_bank #(
  parameter int AW = 6,
  parameter int RW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [RW-1:0] bus_wdata,
  output logic [RW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  input  logic          rx_ferr,
  input  logic          rx_perr,
  output logic          tx_valid,
  output logic [CW-1:0] tx_data,
  input  logic          tx_ack,
  output logic          rx_irq,
  output logic          tx_irq
);
  localparam int WIN   = 16;
  localparam int ON_B  = RW - 1;
  localparam int RDY_B = 0, FE_B = 1, PE_B = 2, IDL_B = 3, EMP_B = 4, FUL_B = 5;
  localparam int RXE_B = 8, TXE_B = 9;
  localparam logic [RW-1:0] HW_MASK = RW'(6'h3F);

  logic [RW-1:0] mode_q, stat_q, baud_q;
  logic [CW-1:0] slot_q;
  logic [RW-1:0] old_v, new_v, stat_mix;

  wire       in_win  = bus_addr < AW'(WIN);
  wire [1:0] grp     = bus_addr[3:2];
  wire [1:0] act     = bus_addr[1:0];
  wire       mode_on = mode_q[ON_B];

  wire hit_mode = bus_wr && in_win && grp == 2'd0;
  wire hit_stat = bus_wr && in_win && grp == 2'd1;
  wire hit_baud = bus_wr && in_win && grp == 2'd3;
  wire hit_tx   = bus_wr && in_win && bus_addr[3:0] == 4'd8;
  wire rd_slot  = bus_rd && in_win && bus_addr[3:0] == 4'd9;

  wire rx_take = rx_valid && mode_on && stat_q[RXE_B];
  wire tx_go   = hit_tx && mode_on && stat_q[TXE_B] && !tx_irq;

  always_comb begin
    case (grp)
      2'd0:    old_v = mode_q;
      2'd1:    old_v = stat_q;
      2'd3:    old_v = baud_q;
      default: old_v = '0;
    endcase
    case (act)
      2'd0: new_v = bus_wdata;
      2'd1: new_v = old_v & ~bus_wdata;
      2'd2: new_v = old_v | bus_wdata;
      default: new_v = old_v ^ bus_wdata;
    endcase
    stat_mix = (stat_q & HW_MASK) | (new_v & ~HW_MASK);
  end

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      case (bus_addr[3:0])
        4'd0:    bus_rdata = mode_q;
        4'd4:    bus_rdata = stat_q;
        4'd9:    bus_rdata = RW'(slot_q);
        4'd12:   bus_rdata = baud_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; stat_q <= '0; baud_q <= '0; slot_q <= '0;
      rx_irq <= 1'b0; tx_irq <= 1'b0; tx_valid <= 1'b0; tx_data <= '0;
    end else begin
      tx_valid <= tx_go;
      if (tx_ack) tx_irq <= 1'b0;
      if (tx_go) begin
        tx_data <= bus_wdata[CW-1:0];
        tx_irq  <= 1'b1;
      end
      if (hit_stat) stat_q <= stat_mix;
      if (hit_baud) baud_q <= new_v;
      if (rd_slot) begin
        stat_q[RDY_B] <= 1'b0;
        rx_irq        <= 1'b0;
      end
      if (rx_take) begin
        slot_q        <= rx_data;
        stat_q[RDY_B] <= 1'b1;
        stat_q[FE_B]  <= rx_ferr;
        stat_q[PE_B]  <= rx_perr;
        rx_irq        <= 1'b1;
      end
      if (hit_stat && !stat_mix[RXE_B]) begin
        rx_irq <= 1'b0;
        stat_q[RDY_B] <= 1'b0; stat_q[FE_B] <= 1'b0; stat_q[PE_B] <= 1'b0;
      end
      if (hit_stat && !stat_mix[TXE_B]) begin
        tx_irq <= 1'b0;
        stat_q[FUL_B] <= 1'b0; stat_q[EMP_B] <= 1'b1;
      end
      if (hit_mode) begin
        mode_q <= new_v;
        if (!new_v[ON_B]) begin
          rx_irq <= 1'b0; tx_irq <= 1'b0;
          stat_q[RDY_B] <= 1'b0; stat_q[FE_B] <= 1'b0; stat_q[PE_B] <= 1'b0;
          stat_q[FUL_B] <= 1'b0;
          stat_q[IDL_B] <= 1'b1; stat_q[EMP_B] <= 1'b1;
        end
      end
    end
  end

  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[ON_B] |-> (!rx_irq && !tx_irq));
  p_rx_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[RXE_B] |-> (!rx_irq && !stat_q[RDY_B]));
  p_tx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[TXE_B] |-> !tx_irq);
  p_irq_matches_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == stat_q[RDY_B]);
  p_read_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_slot && !rx_valid) |=> !rx_irq);
  p_strobe_raises_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_irq);
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && !tx_go) |=> !tx_irq);
endmodule

// File: tb/uart_csr_bank_bench.sv
`timescale 1ns/1ps
module uart_csr_bank_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic rx_valid = 1'b0, rx_ferr = 1'b0, rx_perr = 1'b0, tx_ack = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_valid, rx_irq, tx_irq;
  logic [7:0] tx_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_csr_bank u_uart_csr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ack(tx_ack), .rx_irq(rx_irq), .tx_irq(tx_irq));

  // {write addr, write data, read addr, expected}
  localparam int NV = 22;
  localparam logic [43:0] VEC [NV] = '{
    {6'd12, 16'h1234, 6'd12, 16'h1234}, {6'd13, 16'h0204, 6'd12, 16'h1030},
    {6'd14, 16'h0F00, 6'd12, 16'h1F30}, {6'd15, 16'hFFFF, 6'd12, 16'hE0CF},
    {6'd0,  16'h8001, 6'd0,  16'h8001}, {6'd2,  16'h0010, 6'd0,  16'h8011},
    {6'd3,  16'h0011, 6'd0,  16'h8000}, {6'd1,  16'h0000, 6'd0,  16'h8000},
    {6'd4,  16'hFFFF, 6'd4,  16'hFFC0}, {6'd5,  16'h00C0, 6'd4,  16'hFF00},
    {6'd7,  16'h0300, 6'd4,  16'hFC10}, {6'd6,  16'h0300, 6'd4,  16'hFF10},
    {6'd4,  16'h003F, 6'd4,  16'h0010}, {6'd4,  16'h0300, 6'd4,  16'h0310},
    {6'd1,  16'h8000, 6'd4,  16'h0318}, {6'd2,  16'h8000, 6'd0,  16'h8000},
    {6'd9,  16'h00AA, 6'd9,  16'h0000}, {6'd10, 16'hFFFF, 6'd13, 16'h0000},
    {6'd16, 16'hFFFF, 6'd8,  16'h0000}, {6'd63, 16'hFFFF, 6'd12, 16'hE0CF},
    {6'd12, 16'hE0CF, 6'd2,  16'h0000}, {6'd11, 16'h5555, 6'd63, 16'h0000}};

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a; #1;
    check(bus_rdata, exp, tag);
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1; #1;
    check(bus_rdata, exp, tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic f, input logic p);
    rx_valid = 1'b1; rx_data = b; rx_ferr = f; rx_perr = p;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(6'd0, 16'h0, "R1 mode");
    peek(6'd4, 16'h0, "R1 status");
    peek(6'd12, 16'h0, "R1 baud");
    peek(6'd9, 16'h0, "R1 slot");
    check({13'h0, rx_irq, tx_irq, tx_valid}, 16'h0, "R1 irqs");

    // R2 R3 R4 R6 R5 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][43:38], VEC[i][37:22]);
      rd(VEC[i][21:16], VEC[i][15:0], $sformatf("R2/R3/R4/R9 vector %0d", i));
    end

    // R7 arrival
    push(8'h5A, 1'b1, 1'b0);
    check({15'h0, rx_irq}, 16'h1, "R7 rx irq");
    peek(6'd4, 16'h031B, "R7 status flags");
    rd(6'd9, 16'h005A, "R8 slot read");
    check({15'h0, rx_irq}, 16'h0, "R8 irq cleared");
    peek(6'd4, 16'h031A, "R8 ready cleared");

    // R8 read coinciding with arrival
    push(8'h11, 1'b0, 1'b1);
    rx_valid = 1'b1; rx_data = 8'h22; rx_ferr = 1'b0; rx_perr = 1'b0;
    rd(6'd9, 16'h0011, "R8 first byte");
    rx_valid = 1'b0;
    check({15'h0, rx_irq}, 16'h1, "R8 irq kept on arrival");
    rd(6'd9, 16'h0022, "R8 second byte");
    check({15'h0, rx_irq}, 16'h0, "R8 irq after drain");

    // R10 R11 transmit
    wr(6'd8, 16'h01C3);
    check({7'h0, tx_valid, tx_data}, 16'h01C3, "R10 strobe");
    check({15'h0, tx_irq}, 16'h1, "R10 irq");
    @(negedge clk);
    check({15'h0, tx_valid}, 16'h0, "R10 one cycle");
    wr(6'd8, 16'h0044);
    check({7'h0, tx_valid, tx_data}, 16'h00C3, "R10 blocked while pending");
    tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
    check({15'h0, tx_irq}, 16'h0, "R11 ack clears");
    wr(6'd8, 16'h0055);
    check({7'h0, tx_valid, tx_data}, 16'h0155, "R10 second byte");

    // R6 transmit disable
    wr(6'd5, 16'h0200);
    check({15'h0, tx_irq}, 16'h0, "R6 tx irq dropped");
    peek(6'd4, 16'h0118, "R6 status");

    // R5 receive disable
    push(8'h77, 1'b1, 1'b0);
    check({15'h0, rx_irq}, 16'h1, "R5 pre irq");
    wr(6'd5, 16'h0100);
    check({15'h0, rx_irq}, 16'h0, "R5 rx irq dropped");
    peek(6'd4, 16'h0018, "R5 status");
    push(8'h99, 1'b0, 1'b0);
    check({15'h0, rx_irq}, 16'h0, "R5 arrival ignored irq");
    peek(6'd9, 16'h0077, "R5 arrival ignored slot");

    // R4 module off
    wr(6'd4, 16'h0300);
    push(8'h31, 1'b0, 1'b1);
    wr(6'd8, 16'h0066);
    check({14'h0, rx_irq, tx_irq}, 16'h3, "R4 both pending");
    wr(6'd0, 16'h0000);
    check({14'h0, rx_irq, tx_irq}, 16'h0, "R4 irqs dropped");
    peek(6'd4, 16'h0318, "R4 forced status");
    push(8'h42, 1'b0, 1'b0);
    check({15'h0, rx_irq}, 16'h0, "R4 arrival ignored");
    wr(6'd8, 16'h0088);
    check({15'h0, tx_valid}, 16'h0, "R4 transmit ignored");

    done = 1'b1;
    summary();
  end
endmodule